// File: doc/BRIEF.md
# Serial Gain-Control Word Receiver

This block sits at the device end of a write-only, three-wire serial port made of a frame enable, a serial clock and serial data. It runs on one system clock and oversamples all three pins. Each pin passes through a synchronizer chain and then a stability filter. Rising edges of the serial clock and both edges of the enable are found from these clean copies.

While the active-low enable is asserted, each clean rising edge of the serial clock shifts one data bit into a holding register, most significant bit first. When the enable is released, a frame that delivered exactly one word's worth of clock edges is copied into the output latch, and a one-cycle pulse marks the update. A frame of any other length is thrown away and raises a sticky error flag.

The latched word drives a power-mode select and a gain code. The transmit-enable input selects between transmit-disable and transmit mode. In transmit mode the power-mode bit then picks high-power or low-noise. This input is not filtered and acts at once.

Top module: `gainword_rx`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `hp_mode`, `gain_code`, `word_valid` and `frame_err` are all 0.
- R2: Only while the filtered enable is low does a clean rising edge of the serial clock shift in `ser_dat`, most significant bit first. Serial clock edges while the enable is high change nothing at the outputs.
- R3: `hp_mode` and `gain_code` change only in the cycle in which `word_valid` is 1. They stay unchanged during shifting. `word_valid` is high for exactly one cycle per accepted word.
- R4: Bit 7 of the received word (the first bit sent) drives `hp_mode` (1 = high power, 0 = low noise). Bits 6..0 drive `gain_code`. Every value from 0 to 127 is accepted in both modes.
- R5: If the number of serial clock edges in a frame is not exactly 8, the frame is discarded: the latch keeps its value and `frame_err` becomes 1. The next accepted word clears `frame_err`.
- R6: While `tx_en` is 0, `op_state` is 2'b01 (transmit disabled), whatever the latched word.
- R7: While `tx_en` is 1, `op_state` is 2'b11 if `hp_mode` is 1 and 2'b10 if it is 0. It follows `tx_en` in the same cycle, with no clock edge.
- R8: For an accepted frame, `word_valid` and the new latch contents appear after the SYNC_STAGES+FILT_LEN+1-th system clock edge that follows the enable's rise on the pin. With the default parameters this is the 5th edge.
- R9: A pin pulse shorter than FILT_LEN system clock cycles is ignored. It neither counts as a serial clock edge nor ends a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en_n | input | 1 | Serial frame enable, active low |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| tx_en | input | 1 | External transmit enable |
| hp_mode | output | 1 | Latched power mode: 1 high power, 0 low noise |
| gain_code | output | GAIN_W | Latched gain code |
| op_state | output | 2 | 01 disabled, 10 transmit low noise, 11 transmit high power |
| word_valid | output | 1 | One-cycle pulse on each latch update |
| frame_err | output | 1 | Last frame had the wrong length |

## Verification
The bench drives every pin change on a falling system clock edge. After the enable rises, the latch contents and `word_valid` are due five rising edges later, while `op_state` must follow `tx_en` within the same cycle. A behavioural model in the bench tracks the two synchronizer stages, the filter count and the edge history of each pin. Its expected outputs are compared with the design's at every falling edge. On top of that, the bench counts the edges from the enable release until the pulse appears for each frame, expects exactly five for good frames and none for bad ones, and checks `op_state` one time step after each `tx_en` change.

// File: rtl/gwr_pkg.sv
package gwr_pkg;

   // bit positions of the serial pins inside the packed pin vector
   localparam int PIN_CLK = 0;
   localparam int PIN_EN  = 1;
   localparam int PIN_DAT = 2;
   localparam int NPINS   = 3;

   // decoded transmitter state
   typedef enum logic [1:0] {
      ST_TX_OFF = 2'b01,
      ST_TX_LN  = 2'b10,
      ST_TX_HP  = 2'b11
   } gwr_state_e;

endpackage

// File: rtl/gwr_sync.sv
module gwr_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   initial begin
      if (STAGES < 2) $fatal(1, "gwr_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/gwr_deglitch.sv
module gwr_deglitch #(
   parameter int   FILT_LEN = 2,
   parameter logic RST_VAL  = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   initial begin
      if (FILT_LEN < 0) $fatal(1, "gwr_deglitch: FILT_LEN must not be negative");
   end

   generate
      if (FILT_LEN == 0) begin : g_bypass
         logic unused_bypass;
         assign unused_bypass = ^{clk, rst_n};
         assign q = d;
      end else begin : g_filter
         localparam int CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN);
         localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);
         logic [CW-1:0] run;
         logic          level;

         // the output follows the input once it has differed for FILT_LEN samples
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               level <= RST_VAL;
               run   <= '0;
            end else if (d == level) begin
               run <= '0;
            end else if (run == LAST) begin
               level <= d;
               run   <= '0;
            end else begin
               run <= run + 1'b1;
            end
         end

         assign q = level;
      end
   endgenerate

endmodule

// File: rtl/gwr_frame.sv
module gwr_frame #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              sen_n,
   input  logic              sdat,
   output logic              commit,
   output logic              reject,
   output logic [WORD_W-1:0] shreg
);

   localparam int CNT_MAX = WORD_W + 1;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(CNT_MAX);
   localparam logic [CNT_W-1:0] CNT_GOOD = CNT_W'(WORD_W);

   logic             sclk_d;
   logic             sen_d;
   logic [CNT_W-1:0] nbits;
   logic             clk_rise;
   logic             en_rise;
   logic             en_fall;

   initial begin
      if (WORD_W < 2) $fatal(1, "gwr_frame: WORD_W must be at least 2");
   end

   assign clk_rise = sclk & ~sclk_d;
   assign en_rise  = sen_n & ~sen_d;
   assign en_fall  = ~sen_n & sen_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         sen_d  <= 1'b1;
         nbits  <= '0;
         shreg  <= '0;
      end else begin
         sclk_d <= sclk;
         sen_d  <= sen_n;
         if (en_fall) begin
            nbits <= '0;
         end else if (clk_rise && !sen_n) begin
            shreg <= {shreg[WORD_W-2:0], sdat};
            if (nbits != CNT_SAT) nbits <= nbits + 1'b1;
         end
      end
   end

   assign commit = en_rise && (nbits == CNT_GOOD);
   assign reject = en_rise && (nbits != CNT_GOOD);

endmodule

// File: rtl/gwr_decode.sv
module gwr_decode
   import gwr_pkg::*;
(
   input  logic       tx_en,
   input  logic       mode_hp,
   output gwr_state_e state
);

   always_comb begin
      if (!tx_en)      state = ST_TX_OFF;
      else if (mode_hp) state = ST_TX_HP;
      else             state = ST_TX_LN;
   end

endmodule

// File: rtl/gainword_rx.sv
module gainword_rx
   import gwr_pkg::*;
#(
   parameter int GAIN_W      = 7,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_en_n,
   input  logic              ser_clk,
   input  logic              ser_dat,
   input  logic              tx_en,
   output logic              hp_mode,
   output logic [GAIN_W-1:0] gain_code,
   output logic [1:0]        op_state,
   output logic              word_valid,
   output logic              frame_err
);

   localparam int WORD_W = GAIN_W + 1;
   localparam logic [NPINS-1:0] PIN_IDLE = NPINS'(1) << PIN_EN;

   logic [NPINS-1:0]  raw_pins;
   logic [NPINS-1:0]  sync_pins;
   logic [NPINS-1:0]  clean_pins;
   logic              commit;
   logic              reject;
   logic [WORD_W-1:0] shreg;
   logic [WORD_W-1:0] word_q;
   gwr_state_e        state;

   initial begin
      if (GAIN_W < 1)      $fatal(1, "gainword_rx: GAIN_W must be at least 1");
      if (SYNC_STAGES < 2) $fatal(1, "gainword_rx: SYNC_STAGES must be at least 2");
      if (FILT_LEN < 0)    $fatal(1, "gainword_rx: FILT_LEN must not be negative");
   end

   always_comb begin
      raw_pins          = '0;
      raw_pins[PIN_CLK] = ser_clk;
      raw_pins[PIN_EN]  = ser_en_n;
      raw_pins[PIN_DAT] = ser_dat;
   end

   generate
      for (genvar g = 0; g < NPINS; g++) begin : g_pin
         gwr_sync #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (PIN_IDLE[g])
         ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (raw_pins[g]),
            .q     (sync_pins[g])
         );
         gwr_deglitch #(
            .FILT_LEN (FILT_LEN),
            .RST_VAL  (PIN_IDLE[g])
         ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (sync_pins[g]),
            .q     (clean_pins[g])
         );
      end
   endgenerate

   gwr_frame #(
      .WORD_W (WORD_W)
   ) u_frame (
      .clk    (clk),
      .rst_n  (rst_n),
      .sclk   (clean_pins[PIN_CLK]),
      .sen_n  (clean_pins[PIN_EN]),
      .sdat   (clean_pins[PIN_DAT]),
      .commit (commit),
      .reject (reject),
      .shreg  (shreg)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q     <= '0;
         word_valid <= 1'b0;
         frame_err  <= 1'b0;
      end else begin
         word_valid <= commit;
         if (commit) begin
            word_q    <= shreg;
            frame_err <= 1'b0;
         end else if (reject) begin
            frame_err <= 1'b1;
         end
      end
   end

   assign hp_mode   = word_q[WORD_W-1];
   assign gain_code = word_q[GAIN_W-1:0];

   gwr_decode u_decode (
      .tx_en   (tx_en),
      .mode_hp (hp_mode),
      .state   (state)
   );

   assign op_state = state;

endmodule

// File: rtl/gainword_rx_chk.sv
module gainword_rx_chk #(
   parameter int GAIN_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_en,
   input logic              hp_mode,
   input logic [GAIN_W-1:0] gain_code,
   input logic [1:0]        op_state,
   input logic              word_valid,
   input logic              frame_err
);

   // R3: latch contents move only together with the update pulse
   assert_hold_between_words_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !word_valid |-> $stable({hp_mode, gain_code}));

   // R3: the update pulse lasts one cycle
   assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> !word_valid);

   // R5: an accepted word leaves the error flag clear
   assert_err_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> !frame_err);

   // R5: a rejected frame does not disturb the latch
   assert_reject_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_err) |-> $stable({hp_mode, gain_code}));

   // R6: disabled transmitter
   assert_off_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |-> op_state == 2'b01);

   // R7: transmit state follows the mode bit
   assert_tx_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_en |-> op_state == {1'b1, hp_mode});

endmodule

bind gainword_rx gainword_rx_chk #(.GAIN_W(GAIN_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tx_en      (tx_en),
   .hp_mode    (hp_mode),
   .gain_code  (gain_code),
   .op_state   (op_state),
   .word_valid (word_valid),
   .frame_err  (frame_err)
);

// File: tb/gainword_rx_test.sv
module gainword_rx_test;

   localparam int FL   = 2;
   localparam int HOLD = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_en_n = 1'b1;
   logic       ser_clk = 1'b0;
   logic       ser_dat = 1'b0;
   logic       tx_en = 1'b0;
   logic       hp_mode;
   logic [6:0] gain_code;
   logic [1:0] op_state;
   logic       word_valid;
   logic       frame_err;

   int n_checks = 0;
   int n_fail   = 0;
   int lat      = 0;
   bit done     = 0;

   always #5 clk = ~clk;

   gainword_rx uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ser_en_n   (ser_en_n),
      .ser_clk    (ser_clk),
      .ser_dat    (ser_dat),
      .tx_en      (tx_en),
      .hp_mode    (hp_mode),
      .gain_code  (gain_code),
      .op_state   (op_state),
      .word_valid (word_valid),
      .frame_err  (frame_err)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   // pin order in the model vectors: 0 serial clock, 1 enable, 2 data
   logic [2:0] m_s1, m_s2, m_f;
   int         m_c[3];
   logic       m_pclk, m_pen;
   logic [7:0] m_sh, m_word;
   int         m_cnt;
   logic       m_valid, m_err;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 = 3'b010; m_s2 = 3'b010; m_f = 3'b010;
         for (int k = 0; k < 3; k++) m_c[k] = 0;
         m_pclk = 1'b0; m_pen = 1'b1;
         m_sh = 8'h00; m_word = 8'h00; m_cnt = 0;
         m_valid = 1'b0; m_err = 1'b0;
      end else begin
         bit crise, erise, efall;
         crise = m_f[0] && !m_pclk;
         erise = m_f[1] && !m_pen;
         efall = !m_f[1] && m_pen;
         m_valid = 1'b0;
         if (efall) m_cnt = 0;
         else if (crise && !m_f[1]) begin
            m_sh = {m_sh[6:0], m_f[2]};
            if (m_cnt < 9) m_cnt++;
         end
         if (erise) begin
            if (m_cnt == 8) begin
               m_word = m_sh; m_valid = 1'b1; m_err = 1'b0;
            end else m_err = 1'b1;
         end
         m_pclk = m_f[0];
         m_pen  = m_f[1];
         for (int k = 0; k < 3; k++) begin
            if (m_s2[k] == m_f[k]) m_c[k] = 0;
            else if (m_c[k] == FL - 1) begin m_f[k] = m_s2[k]; m_c[k] = 0; end
            else m_c[k]++;
         end
         m_s2 = m_s1;
         m_s1 = {ser_dat, ser_en_n, ser_clk};
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         logic [1:0] exp_st;
         exp_st = tx_en ? {1'b1, m_word[7]} : 2'b01;
         check(hp_mode === m_word[7], "R4 model hp_mode", hp_mode, m_word[7]);
         check(gain_code === m_word[6:0], "R4 model gain_code", gain_code, m_word[6:0]);
         check(word_valid === m_valid, "R3 model word_valid", word_valid, m_valid);
         check(frame_err === m_err, "R5 model frame_err", frame_err, m_err);
         check(op_state === exp_st, "R6/R7 model op_state", op_state, exp_st);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic hold(input int n);
      repeat (n) @(negedge clk);
   endtask

   // glitch_at / eglitch_at: bit index before whose clock a one-cycle pulse is injected (-1 none)
   task automatic send(input logic [15:0] bits, input int nbits, input int glitch_at, input int eglitch_at);
      ser_en_n = 1'b0;
      hold(HOLD);
      for (int i = nbits - 1; i >= 0; i--) begin
         ser_dat = bits[i];
         hold(HOLD);
         if (glitch_at == i) begin ser_clk = 1'b1; hold(1); ser_clk = 1'b0; hold(HOLD); end
         if (eglitch_at == i) begin ser_en_n = 1'b1; hold(1); ser_en_n = 1'b0; hold(HOLD); end
         ser_clk = 1'b1; hold(HOLD);
         ser_clk = 1'b0; hold(HOLD);
         // R3: nothing moves while shifting
         if (i == nbits / 2) check(word_valid === 1'b0, "R3 no pulse mid-frame", word_valid, 0);
      end
      ser_en_n = 1'b1;
      lat = 0;
      for (int i = 1; i <= 12; i++) begin
         @(negedge clk);
         if (word_valid && lat == 0) lat = i;
      end
      hold(4);
   endtask

   task automatic expect_word(input logic [7:0] w, input string tag);
      check(hp_mode === w[7], {tag, " hp_mode"}, hp_mode, w[7]);
      check(gain_code === w[6:0], {tag, " gain_code"}, gain_code, w[6:0]);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_checks++; n_fail++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   // ---------------- main sequence ----------------
   initial begin
      hold(3);
      check(hp_mode === 1'b0 && gain_code === 7'd0, "R1 latch in reset", {hp_mode, gain_code}, 0);
      check(word_valid === 1'b0 && frame_err === 1'b0, "R1 flags in reset", {word_valid, frame_err}, 0);
      rst_n = 1'b1;
      hold(1);
      check(gain_code === 7'd0 && frame_err === 1'b0, "R1 after release", {frame_err, gain_code}, 0);

      // high-power word, gain 87
      tx_en = 1'b1;
      send(16'hD7, 8, -1, -1);
      check(lat == 5, "R8 latency", lat, 5);
      expect_word(8'hD7, "R4 hp word");
      check(op_state === 2'b11, "R7 high power state", op_state, 3);

      // low-noise word, gain 115
      send(16'h73, 8, -1, -1);
      check(lat == 5, "R8 latency ln", lat, 5);
      expect_word(8'h73, "R4 ln word");
      check(op_state === 2'b10, "R7 low noise state", op_state, 2);

      // transmit enable off, same cycle
      tx_en = 1'b0;
      #1;
      check(op_state === 2'b01, "R6 disabled", op_state, 1);
      expect_word(8'h73, "R6 word kept");
      hold(3);
      tx_en = 1'b1;
      #1;
      check(op_state === 2'b10, "R7 same-cycle enable", op_state, 2);

      // short frame
      send(16'h7F, 7, -1, -1);
      check(lat == 0, "R5 no pulse short", lat, 0);
      check(frame_err === 1'b1, "R5 short flagged", frame_err, 1);
      expect_word(8'h73, "R5 short kept");

      // long frame
      send(16'h1AB, 9, -1, -1);
      check(lat == 0, "R5 no pulse long", lat, 0);
      check(frame_err === 1'b1, "R5 long flagged", frame_err, 1);
      expect_word(8'h73, "R5 long kept");

      // extremes of the gain range; good frame clears the flag
      send(16'h00, 8, -1, -1);
      check(frame_err === 1'b0, "R5 flag cleared", frame_err, 0);
      expect_word(8'h00, "R4 gain zero");
      send(16'hFF, 8, -1, -1);
      expect_word(8'hFF, "R4 gain max");
      send(16'h7F, 8, -1, -1);
      expect_word(8'h7F, "R4 ln max gain");

      // serial clock toggles with enable high are ignored
      for (int i = 0; i < 5; i++) begin
         ser_dat = i[0];
         ser_clk = 1'b1; hold(HOLD);
         ser_clk = 1'b0; hold(HOLD);
      end
      check(word_valid === 1'b0 && frame_err === 1'b0, "R2 idle clocks", {word_valid, frame_err}, 0);
      expect_word(8'h7F, "R2 idle clocks word");
      send(16'h2C, 8, -1, -1);
      expect_word(8'h2C, "R2 msb first");

      // short glitches on the serial clock and on the enable
      send(16'h5A, 8, 4, -1);
      check(lat == 5, "R9 clock glitch latency", lat, 5);
      expect_word(8'h5A, "R9 clock glitch");
      check(frame_err === 1'b0, "R9 clock glitch flag", frame_err, 0);
      send(16'hA5, 8, -1, 3);
      expect_word(8'hA5, "R9 enable glitch");
      check(frame_err === 1'b0, "R9 enable glitch flag", frame_err, 0);

      hold(5);
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule